// File: doc/BRIEF.md
# Transfer Activation Phase Sequencer

This block reproduces, cycle for cycle, the bus-state timeline of a single activation of a descriptor-driven data transfer engine. A one-cycle start strobe launches the activation. The sequencer then walks through a fixed series of phases: a vector fetch, a descriptor register read/write, a data read and a data write, and a closing internal operation. Each phase is held for as many clock cycles as its accesses would occupy on the bus. The length of a phase is its number of accesses multiplied by the state cost of one access. That cost depends on the target region (on-chip memory, or a slow or very slow peripheral) and on the data size.

Chained transfers repeat the descriptor, read and write phases once for each extra link. The vector fetch and the internal operation happen once per activation. The block reports the current phase, a busy flag, a one-cycle done pulse and a running count of elapsed states. A performance model or a bus scheduler can use these outputs to reserve the exact number of bus cycles that an activation costs. No addresses, data or descriptors are handled here.

Top module: `xfer_phase_seq`

## Requirements
- R1: A start pulse sampled while idle is accepted; on the next cycle busy is 1, phase is 1 (vector fetch) and state_cnt is 0.
- R2: Phase codes are 0 idle, 1 vector fetch, 2 descriptor access, 3 data read, 4 data write, 5 internal operation. An activation visits them in this order: 1, then (2, 3, 4) once per transfer, then 5, then 0.
- R3: The vector fetch and the internal operation each last exactly one state per activation. The descriptor phase lasts 7 states per transfer.
- R4: The data read and data write phases each perform one access when mode is 0 (normal), 1 (repeat) or 3. They perform N accesses when mode is 2 (block), where N is blk_size, and a blk_size of 0 counts as 1.
- R5: The cost of one data access is set by its region and size codes. Region 00 (on-chip memory) and region 11 cost 1 state for any size. Region 01 costs 2 states for size 00 (byte) or 01 (word), and 4 states for size 10 (longword) or 11. Region 10 costs 3 states for byte or word, and 6 states for longword or 11. The read side uses the src codes and the write side uses the dst codes.
- R6: chain_cnt gives the number of extra chained transfers C. The descriptor, read and write phases run C+1 times in total.
- R7: state_cnt rises by one for every busy cycle. It holds the activation's total from the done cycle until the next accepted start.
- R8: done is high for exactly one cycle, in the cycle right after the last internal-operation state, and busy is 0 in that cycle. The number of busy cycles equals 2 + (C+1)·(7 + N·cost_src + N·cost_dst).
- R9: A start pulse that arrives while busy has no effect on the phase sequence, on the total or on the latched settings.
- R10: After reset, phase is 0, busy is 0, done is 0 and state_cnt is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Activation request strobe |
| mode | input | 2 | Transfer mode: 0 normal, 1 repeat, 2 block, 3 treated as normal |
| blk_size | input | BLK_W | Accesses per data phase in block mode (0 means 1) |
| chain_cnt | input | CHN_W | Number of extra chained transfers |
| src_region | input | 2 | Region code of the read side |
| src_size | input | 2 | Size code of the read side |
| dst_region | input | 2 | Region code of the write side |
| dst_size | input | 2 | Size code of the write side |
| phase | output | 3 | Current phase code |
| busy | output | 1 | Activation in progress |
| done | output | 1 | One-cycle completion pulse |
| state_cnt | output | CNT_W | Running count of elapsed states |

## Verification
On every cycle the assertions check the local rules. Phase steps must be legal, and the vector fetch and internal operation must each last a single state. The done pulse must be one cycle wide and must follow the internal operation. The state counter must rise by one in each busy cycle, and an accepted start must clear the counter. The length of each phase, however, comes from the cost table, the block size and the chain depth. Only the bench's scenarios show these lengths: it totals the cycles spent in each phase and compares the grand total against the formula. Those scenarios also show that a start arriving mid-run leaves the total unchanged.

// File: rtl/xps_pkg.sv
package xps_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_VEC  = 3'd1,
        PH_REG  = 3'd2,
        PH_RD   = 3'd3,
        PH_WR   = 3'd4,
        PH_INT  = 3'd5
    } phase_e;

    typedef enum logic [1:0] {
        MD_NORMAL = 2'd0,
        MD_REPEAT = 2'd1,
        MD_BLOCK  = 2'd2,
        MD_RSVD   = 2'd3
    } mode_e;

    localparam int COST_W       = 3;
    localparam int REG_ACCESSES = 7;

    typedef struct packed {
        logic [COST_W-1:0] rd;
        logic [COST_W-1:0] wr;
    } cost_pair_t;

    // States consumed by one data access, by target region and data size.
    function automatic logic [COST_W-1:0] access_cost(input logic [1:0] region,
                                                      input logic [1:0] size);
        logic wide;
        wide = size[1];
        case (region)
            2'b01:   return wide ? COST_W'(4) : COST_W'(2);
            2'b10:   return wide ? COST_W'(6) : COST_W'(3);
            default: return COST_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/xps_access_cost.sv
module xps_access_cost
    import xps_pkg::*;
(
    input  logic [1:0]        region,
    input  logic [1:0]        size,
    output logic [COST_W-1:0] cost
);
    always_comb cost = access_cost(region, size);
endmodule

// File: rtl/xps_dwell_timer.sv
module xps_dwell_timer #(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    output logic             last
);
    logic [LEN_W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst)               rem_q <= '0;
        else if (load)         rem_q <= len - LEN_W'(1);
        else if (rem_q != '0)  rem_q <= rem_q - LEN_W'(1);
    end

    assign last = (rem_q == '0);
endmodule

// File: rtl/xfer_phase_seq.sv
module xfer_phase_seq
    import xps_pkg::*;
#(
    parameter int BLK_W = 8,
    parameter int CHN_W = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       mode,
    input  logic [BLK_W-1:0] blk_size,
    input  logic [CHN_W-1:0] chain_cnt,
    input  logic [1:0]       src_region,
    input  logic [1:0]       src_size,
    input  logic [1:0]       dst_region,
    input  logic [1:0]       dst_size,
    output logic [2:0]       phase,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] state_cnt
);
    localparam int LEN_W = BLK_W + COST_W;

    phase_e           phase_q, phase_nxt;
    logic [BLK_W-1:0] n_q, n_eff;
    logic [CHN_W-1:0] chain_left_q;
    cost_pair_t       cost_q, cost_in;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic             accept, advance, chain_dec, tmr_load, tmr_last;
    logic [LEN_W-1:0] len_nxt;

    xps_access_cost u_cost_rd (.region(src_region), .size(src_size), .cost(cost_in.rd));
    xps_access_cost u_cost_wr (.region(dst_region), .size(dst_size), .cost(cost_in.wr));

    xps_dwell_timer #(.LEN_W(LEN_W)) u_dwell (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .len  (len_nxt),
        .last (tmr_last)
    );

    assign accept = start && (phase_q == PH_IDLE);

    always_comb begin
        if (mode_e'(mode) == MD_BLOCK)
            n_eff = (blk_size == '0) ? BLK_W'(1) : blk_size;
        else
            n_eff = BLK_W'(1);
    end

    always_comb begin
        phase_nxt = phase_q;
        advance   = 1'b0;
        chain_dec = 1'b0;
        if (accept) begin
            phase_nxt = PH_VEC;
            advance   = 1'b1;
        end else if (phase_q != PH_IDLE && tmr_last) begin
            advance = 1'b1;
            case (phase_q)
                PH_VEC: phase_nxt = PH_REG;
                PH_REG: phase_nxt = PH_RD;
                PH_RD:  phase_nxt = PH_WR;
                PH_WR: begin
                    if (chain_left_q != '0) begin
                        phase_nxt = PH_REG;
                        chain_dec = 1'b1;
                    end else begin
                        phase_nxt = PH_INT;
                    end
                end
                default: phase_nxt = PH_IDLE;
            endcase
        end
    end

    always_comb begin
        case (phase_nxt)
            PH_REG:  len_nxt = LEN_W'(REG_ACCESSES);
            PH_RD:   len_nxt = LEN_W'(n_q) * LEN_W'(cost_q.rd);
            PH_WR:   len_nxt = LEN_W'(n_q) * LEN_W'(cost_q.wr);
            default: len_nxt = LEN_W'(1);
        endcase
    end

    assign tmr_load = advance && (phase_nxt != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q      <= PH_IDLE;
            n_q          <= BLK_W'(1);
            chain_left_q <= '0;
            cost_q       <= '0;
            cnt_q        <= '0;
            done_q       <= 1'b0;
        end else begin
            phase_q <= phase_nxt;
            done_q  <= (phase_q == PH_INT) && tmr_last;
            if (accept) begin
                n_q          <= n_eff;
                cost_q       <= cost_in;
                chain_left_q <= chain_cnt;
                cnt_q        <= '0;
            end else begin
                if (chain_dec)          chain_left_q <= chain_left_q - CHN_W'(1);
                if (phase_q != PH_IDLE) cnt_q        <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign phase     = phase_q;
    assign busy      = (phase_q != PH_IDLE);
    assign done      = done_q;
    assign state_cnt = cnt_q;

endmodule

// File: rtl/xps_checker.sv
module xps_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [2:0]       phase,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] state_cnt
);
    assert_idle_start_R1: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd0 && start) |=> (busy && phase == 3'd1 && state_cnt == '0));

    assert_idle_exit_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd0 && !start) |=> (phase == 3'd0));

    assert_reg_step_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd2) |=> (phase == 3'd2 || phase == 3'd3));

    assert_rd_step_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd3) |=> (phase == 3'd3 || phase == 3'd4));

    assert_wr_step_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd4) |=> (phase == 3'd4 || phase == 3'd2 || phase == 3'd5));

    assert_vec_single_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd1) |=> (phase == 3'd2));

    assert_int_single_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd5) |=> (phase == 3'd0 && done));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(phase) == 3'd5));

    assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> (state_cnt == $past(state_cnt) + CNT_W'(1)));

    assert_count_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(state_cnt));

    assert_busy_start_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && start && phase != 3'd5) |=> busy);

    assert_phase_range_R2: assert property (@(posedge clk) disable iff (rst)
        phase <= 3'd5);
endmodule

bind xfer_phase_seq xps_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .phase     (phase),
    .busy      (busy),
    .done      (done),
    .state_cnt (state_cnt)
);

// File: tb/xfer_phase_seq_tb.sv
`timescale 1ns/1ps
module xfer_phase_seq_tb;
    localparam int BLK_W = 8;
    localparam int CHN_W = 4;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [1:0]       mode = '0;
    logic [BLK_W-1:0] blk_size = '0;
    logic [CHN_W-1:0] chain_cnt = '0;
    logic [1:0]       src_region = '0, src_size = '0, dst_region = '0, dst_size = '0;
    logic [2:0]       phase;
    logic             busy, done;
    logic [CNT_W-1:0] state_cnt;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    xfer_phase_seq #(.BLK_W(BLK_W), .CHN_W(CHN_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .blk_size(blk_size),
        .chain_cnt(chain_cnt), .src_region(src_region), .src_size(src_size),
        .dst_region(dst_region), .dst_size(dst_size), .phase(phase), .busy(busy),
        .done(done), .state_cnt(state_cnt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_cost(input int r, input int s);
        if (r == 1) return (s >= 2) ? 4 : 2;
        if (r == 2) return (s >= 2) ? 6 : 3;
        return 1;
    endfunction

    function automatic bit step_ok(input int p, input int c);
        case (p)
            0: return c == 1;
            1: return c == 2;
            2: return c == 2 || c == 3;
            3: return c == 3 || c == 4;
            4: return c == 4 || c == 2 || c == 5;
            default: return 1'b0;
        endcase
    endfunction

    task automatic run(input int md, input int bs, input int ch, input int sr, input int ss,
                       input int dr, input int ds, input int poke);
        int n, sc, dc, total, busy_cycles, guard, prev;
        int pc[6];
        bit order_ok, timeout;
        n  = (md == 2) ? ((bs == 0) ? 1 : bs) : 1;
        sc = exp_cost(sr, ss);
        dc = exp_cost(dr, ds);
        total = 2 + (ch + 1) * (7 + n * sc + n * dc);
        foreach (pc[i]) pc[i] = 0;
        busy_cycles = 0; guard = 0; prev = 0; order_ok = 1'b1; timeout = 1'b0;

        @(negedge clk);
        mode = 2'(md); blk_size = BLK_W'(bs); chain_cnt = CHN_W'(ch);
        src_region = 2'(sr); src_size = 2'(ss); dst_region = 2'(dr); dst_size = 2'(ds);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && phase == 3'd1 && state_cnt == '0, "R1 start accepted", int'(phase), 1);

        while (!done) begin
            start = 1'b0;
            if (busy) begin
                busy_cycles++;
                if (phase <= 3'd5) pc[phase]++;
                if (!step_ok(prev, int'(phase)) && phase != 3'(prev)) order_ok = 1'b0;
                prev = int'(phase);
            end
            if (poke != 0 && busy_cycles == poke) begin
                // R9: a different request mid-run must not alter the activation
                start = 1'b1; mode = 2'd2; blk_size = 8'd200; chain_cnt = 4'd9;
                src_region = 2'd2; src_size = 2'd2;
            end
            @(negedge clk);
            guard++;
            if (guard > 60000) begin timeout = 1'b1; break; end
        end
        start = 1'b0;
        chk(!timeout, "R8 done reached", guard, total);
        chk(done && !busy, "R8 done with busy low", int'(busy), 0);
        chk(busy_cycles == total, "R8/R9 busy cycles", busy_cycles, total);
        chk(int'(state_cnt) == total, "R7 state count at done", int'(state_cnt), total);
        chk(pc[1] == 1 && pc[5] == 1, "R3 vector/internal single", pc[1] + pc[5], 2);
        chk(pc[2] == 7 * (ch + 1), "R3/R6 descriptor states", pc[2], 7 * (ch + 1));
        chk(pc[3] == (ch + 1) * n * sc, "R4/R5 read states", pc[3], (ch + 1) * n * sc);
        chk(pc[4] == (ch + 1) * n * dc, "R4/R5 write states", pc[4], (ch + 1) * n * dc);
        chk(order_ok && prev == 5, "R2 phase order", prev, 5);
        @(negedge clk);
        chk(!done && !busy, "R8 done one cycle", int'(done), 0);
        chk(int'(state_cnt) == total, "R7 count holds", int'(state_cnt), total);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20417));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(phase == 3'd0 && !busy && !done && state_cnt == '0, "R10 reset state",
            int'(phase), 0);

        // Directed corner cases
        run(0, 0, 0, 0, 0, 0, 0, 0);          // all on-chip, total 11
        run(2, 0, 0, 1, 0, 2, 1, 0);          // R4 block size 0 as 1
        run(0, 200, 0, 1, 2, 2, 2, 0);        // R4 block size ignored in normal mode
        run(3, 50, 1, 2, 3, 1, 3, 0);         // R4 mode 3 as normal, R5 size 11 as long
        run(2, 255, 1, 2, 2, 2, 2, 0);        // R4/R5 longest phases
        run(1, 0, 15, 3, 2, 0, 1, 3);         // R6 deepest chain, R5 region 11, R9 poke
        run(2, 4, 2, 1, 1, 0, 2, 1);          // R9 poke on first busy cycle

        for (int k = 0; k < 40; k++) begin
            run(int'($urandom % 4), int'($urandom % 9), int'($urandom % 4),
                int'($urandom % 4), int'($urandom % 4), int'($urandom % 4),
                int'($urandom % 4), (($urandom % 3) == 0) ? int'(1 + $urandom % 5) : 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule